// File: doc/BRIEF.md
# USB Device Interrupt Status Unit

This unit gathers the interrupt causes of a full-speed USB device controller and presents them to a microcontroller. Each cause is held in a sticky flag. The causes are six per-endpoint transaction-complete events, a bus reset, a change of suspend state and the end of a DMA transfer. The flags are reported as two status bytes and summarised on one active-low interrupt line. The unit also works out the suspend state itself. It counts 1 ms frame ticks since the last start-of-frame (SOF) marker, and enters suspend once a set number of frame periods pass with no SOF.

The microcontroller drives a small command channel with a valid/ready handshake. One command reads the status: the unit answers with a two-byte response stream, status byte A first and then status byte B. The other command names an endpoint and acknowledges it. That endpoint's last-transaction-status register lives outside this unit, so the command only retires that endpoint's flag and produces no response.

Back-pressure rules:
- The command channel accepts a command only while no response is pending.
- A response byte stays offered until `rsp_ready` takes it.
- The offered byte follows the live flags, so an event that lands during a stall is reported rather than lost.

On a bus reset the unit returns to its power-up state, with two exceptions: it flags the reset as an interrupt, and it pulses `addr_clear` so the device address returns to 0.

Top module: `usb_irq_status`

## Requirements
- R1: A pulse on `ep_done[i]` sets the flag for endpoint i, and that flag appears in bit i of status byte A. In a status read, byte A is returned first and byte B second.
- R2: An endpoint flag is cleared only by an endpoint-acknowledge command (`cmd_op`=1) whose `cmd_ep` equals that endpoint's index. Reading the status bytes leaves the endpoint flags unchanged.
- R3: A pulse on `bus_reset_det` has the following effects:
  - It sets bit 6 of byte A.
  - It clears all other flags.
  - It leaves the device awake and restarts the frame count.
  - It raises `addr_clear` for the one cycle after the pulse.
- R4: Suppose MISS_LIMIT (default 3) frame ticks arrive with no SOF since the last SOF or reset. Then `suspended` rises in the cycle after the last of those ticks, and bit 7 of byte A (suspend change) is set. Further ticks while suspended set nothing.
- R5: Every SOF restarts the frame count. An SOF received while suspended clears `suspended` and sets bit 7 of byte A again.
- R6: Bits 6 and 7 of byte A clear when byte A is accepted. Bit 0 of byte B (DMA end-of-transfer, set by a `dma_eot` pulse) clears when byte B is accepted. Bits 7..1 of byte B always read 0.
- R7: `irq_n` is low while any flag in either byte is set, and high when all flags are clear.
- R8: If a setting event and a clearing action hit the same flag in the same cycle, the flag stays set.
- R9: The command and response channels follow these rules:
  - `cmd_ready` is high only while no response is pending.
  - `cmd_op`=0 starts a status read.
  - The response is two beats, with `rsp_last` high on the second.
  - A beat stays valid until it is accepted.
- R10: An endpoint-acknowledge command with `cmd_ep` of NUM_EP or above changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| ep_done | input | NUM_EP | Per-endpoint transaction-complete pulses |
| sof_pulse | input | 1 | Start-of-frame received pulse |
| frame_tick | input | 1 | 1 ms frame-period tick |
| bus_reset_det | input | 1 | USB bus reset detected pulse |
| dma_eot | input | 1 | DMA end-of-transfer pulse |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted this cycle if valid |
| cmd_op | input | 1 | 0 = read status, 1 = acknowledge endpoint |
| cmd_ep | input | EP_IDX_W | Endpoint index for acknowledge |
| rsp_valid | output | 1 | Response byte offered |
| rsp_ready | input | 1 | Host takes the response byte |
| rsp_last | output | 1 | Second (final) response byte |
| rsp_data | output | 8 | Response byte |
| irq_n | output | 1 | Active-low interrupt request |
| suspended | output | 1 | Device is in suspend state |
| addr_clear | output | 1 | One-cycle request to reset device address to 0 |

## Verification
The checker relies on the following input assumptions:
- Every event input is a synchronous pulse one cycle wide.
- The host only drops `rsp_ready` between beats and never withdraws the response channel itself.
- `rsp_data` is not required to be stable during a stall, because it tracks the live flags by design. The checker only demands that valid and the beat position hold.

The bench drives every input on the falling edge as one-cycle pulses. It completes each status read it starts, and it places simultaneous event-and-clear cases deliberately on the accepting cycle of a byte.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;

  typedef enum logic {
    OP_READ_STATUS = 1'b0,
    OP_EP_ACK      = 1'b1
  } cmd_op_e;

  typedef enum logic [1:0] {
    RS_IDLE  = 2'd0,
    RS_BYTEA = 2'd1,
    RS_BYTEB = 2'd2
  } rd_state_e;

  localparam int BYTE_W       = 8;
  localparam int BIT_BUSRST   = 6;
  localparam int BIT_SUSPCHG  = 7;
  localparam int BIT_DMA      = 0;

endpackage

// File: rtl/usb_irq_suspend_det.sv
module usb_irq_suspend_det #(
  parameter int MISS_LIMIT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_reset,
  input  logic sof,
  input  logic frame_tick,
  output logic suspended,
  output logic susp_event
);
  localparam int CNT_W = $clog2(MISS_LIMIT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MISS_LIMIT - 1);

  logic [CNT_W-1:0] miss_cnt;
  logic             susp_q;
  logic             go_sleep;
  logic             go_wake;

  assign go_sleep = frame_tick && !sof && !susp_q && (miss_cnt == LAST);
  assign go_wake  = sof && susp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      miss_cnt <= '0;
      susp_q   <= 1'b0;
    end else if (bus_reset) begin
      miss_cnt <= '0;
      susp_q   <= 1'b0;
    end else if (sof) begin
      miss_cnt <= '0;
      susp_q   <= 1'b0;
    end else if (frame_tick && !susp_q) begin
      if (go_sleep) begin
        miss_cnt <= '0;
        susp_q   <= 1'b1;
      end else begin
        miss_cnt <= miss_cnt + 1'b1;
      end
    end
  end

  assign suspended  = susp_q;
  assign susp_event = !bus_reset && (go_sleep || go_wake);

endmodule

// File: rtl/usb_irq_flags.sv
module usb_irq_flags #(
  parameter int NUM_EP   = 6,
  parameter int EP_IDX_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_EP-1:0]   ep_done,
  input  logic                ep_clr,
  input  logic [EP_IDX_W-1:0] ep_clr_idx,
  input  logic                bus_reset,
  input  logic                susp_event,
  input  logic                dma_eot,
  input  logic                clr_byte_a,
  input  logic                clr_byte_b,
  output logic [NUM_EP-1:0]   ep_flags,
  output logic                busrst_flag,
  output logic                suspchg_flag,
  output logic                dma_flag
);

  for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
    logic hit;
    assign hit = ep_clr && (ep_clr_idx == EP_IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          ep_flags[g] <= 1'b0;
      else if (ep_done[g]) ep_flags[g] <= 1'b1;
      else if (bus_reset)  ep_flags[g] <= 1'b0;
      else if (hit)        ep_flags[g] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busrst_flag  <= 1'b0;
      suspchg_flag <= 1'b0;
      dma_flag     <= 1'b0;
    end else begin
      if (bus_reset)       busrst_flag <= 1'b1;
      else if (clr_byte_a) busrst_flag <= 1'b0;

      if (susp_event)      suspchg_flag <= 1'b1;
      else if (bus_reset)  suspchg_flag <= 1'b0;
      else if (clr_byte_a) suspchg_flag <= 1'b0;

      if (dma_eot)         dma_flag <= 1'b1;
      else if (bus_reset)  dma_flag <= 1'b0;
      else if (clr_byte_b) dma_flag <= 1'b0;
    end
  end

endmodule

// File: rtl/usb_irq_rd_seq.sv
module usb_irq_rd_seq
  import usb_irq_pkg::*;
#(
  parameter int EP_IDX_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic                cmd_op,
  input  logic [EP_IDX_W-1:0] cmd_ep,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic                rsp_last,
  output logic                clr_byte_a,
  output logic                clr_byte_b,
  output logic                ep_clr,
  output logic [EP_IDX_W-1:0] ep_clr_idx
);
  rd_state_e state, state_nx;
  logic      cmd_fire;
  cmd_op_e   op;

  assign op        = cmd_op_e'(cmd_op);
  assign cmd_ready = (state == RS_IDLE);
  assign cmd_fire  = cmd_valid && cmd_ready;
  assign rsp_valid = (state == RS_BYTEA) || (state == RS_BYTEB);
  assign rsp_last  = (state == RS_BYTEB);

  assign clr_byte_a = (state == RS_BYTEA) && rsp_ready;
  assign clr_byte_b = (state == RS_BYTEB) && rsp_ready;
  assign ep_clr     = cmd_fire && (op == OP_EP_ACK);
  assign ep_clr_idx = cmd_ep;

  always_comb begin
    state_nx = state;
    unique case (state)
      RS_IDLE:  if (cmd_fire && op == OP_READ_STATUS) state_nx = RS_BYTEA;
      RS_BYTEA: if (rsp_ready) state_nx = RS_BYTEB;
      RS_BYTEB: if (rsp_ready) state_nx = RS_IDLE;
      default:  state_nx = RS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= RS_IDLE;
    else        state <= state_nx;
  end

endmodule

// File: rtl/usb_irq_status.sv
module usb_irq_status
  import usb_irq_pkg::*;
#(
  parameter int NUM_EP     = 6,
  parameter int MISS_LIMIT = 3,
  parameter int EP_IDX_W   = (NUM_EP > 1) ? $clog2(NUM_EP + 1) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_EP-1:0]   ep_done,
  input  logic                sof_pulse,
  input  logic                frame_tick,
  input  logic                bus_reset_det,
  input  logic                dma_eot,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic                cmd_op,
  input  logic [EP_IDX_W-1:0] cmd_ep,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic                rsp_last,
  output logic [7:0]          rsp_data,
  output logic                irq_n,
  output logic                suspended,
  output logic                addr_clear
);
  logic [NUM_EP-1:0]   ep_flags;
  logic                busrst_flag, suspchg_flag, dma_flag;
  logic                susp_event;
  logic                clr_byte_a, clr_byte_b;
  logic                ep_clr;
  logic [EP_IDX_W-1:0] ep_clr_idx;
  logic [BYTE_W-1:0]   byte_a, byte_b;

  usb_irq_suspend_det #(.MISS_LIMIT(MISS_LIMIT)) u_susp (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_reset  (bus_reset_det),
    .sof        (sof_pulse),
    .frame_tick (frame_tick),
    .suspended  (suspended),
    .susp_event (susp_event)
  );

  usb_irq_rd_seq #(.EP_IDX_W(EP_IDX_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_op     (cmd_op),
    .cmd_ep     (cmd_ep),
    .rsp_valid  (rsp_valid),
    .rsp_ready  (rsp_ready),
    .rsp_last   (rsp_last),
    .clr_byte_a (clr_byte_a),
    .clr_byte_b (clr_byte_b),
    .ep_clr     (ep_clr),
    .ep_clr_idx (ep_clr_idx)
  );

  usb_irq_flags #(.NUM_EP(NUM_EP), .EP_IDX_W(EP_IDX_W)) u_flags (
    .clk          (clk),
    .rst_n        (rst_n),
    .ep_done      (ep_done),
    .ep_clr       (ep_clr),
    .ep_clr_idx   (ep_clr_idx),
    .bus_reset    (bus_reset_det),
    .susp_event   (susp_event),
    .dma_eot      (dma_eot),
    .clr_byte_a   (clr_byte_a),
    .clr_byte_b   (clr_byte_b),
    .ep_flags     (ep_flags),
    .busrst_flag  (busrst_flag),
    .suspchg_flag (suspchg_flag),
    .dma_flag     (dma_flag)
  );

  always_comb begin
    byte_a = '0;
    byte_a[NUM_EP-1:0]  = ep_flags;
    byte_a[BIT_BUSRST]  = busrst_flag;
    byte_a[BIT_SUSPCHG] = suspchg_flag;
    byte_b = '0;
    byte_b[BIT_DMA]     = dma_flag;
  end

  assign rsp_data = rsp_last ? byte_b : byte_a;
  assign irq_n    = !((|byte_a) || (|byte_b));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_clear <= 1'b0;
    else        addr_clear <= bus_reset_det;
  end

endmodule

// File: rtl/usb_irq_status_chk.sv
module usb_irq_status_chk #(
  parameter int NUM_EP = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_EP-1:0] ep_done,
  input logic              sof_pulse,
  input logic              bus_reset_det,
  input logic              dma_eot,
  input logic              cmd_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic              rsp_last,
  input logic [7:0]        rsp_data,
  input logic              irq_n,
  input logic              suspended,
  input logic              addr_clear
);

  assert_ep_irq_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (|ep_done) |=> !irq_n);

  assert_busreset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset_det |=> (!irq_n && !suspended && addr_clear));

  assert_susp_change_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(suspended) || $fell(suspended)) |-> !irq_n);

  assert_sof_wakes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sof_pulse |=> !suspended);

  assert_byteb_reserved_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_last) |-> (rsp_data[7:1] == 7'd0));

  assert_dma_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dma_eot |=> !irq_n);

  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_last)));

  assert_ready_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !rsp_valid);

endmodule

bind usb_irq_status usb_irq_status_chk #(.NUM_EP(NUM_EP)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ep_done       (ep_done),
  .sof_pulse     (sof_pulse),
  .bus_reset_det (bus_reset_det),
  .dma_eot       (dma_eot),
  .cmd_ready     (cmd_ready),
  .rsp_valid     (rsp_valid),
  .rsp_ready     (rsp_ready),
  .rsp_last      (rsp_last),
  .rsp_data      (rsp_data),
  .irq_n         (irq_n),
  .suspended     (suspended),
  .addr_clear    (addr_clear)
);

// File: tb/usb_irq_status_test.sv
module usb_irq_status_test;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_EP     = 6;
  localparam int MISS_LIMIT = 3;
  localparam int EP_IDX_W   = 3;

  logic                clk = 1'b0;
  logic                rst_n;
  logic [NUM_EP-1:0]   ep_done;
  logic                sof_pulse, frame_tick, bus_reset_det, dma_eot;
  logic                cmd_valid, cmd_ready, cmd_op;
  logic [EP_IDX_W-1:0] cmd_ep;
  logic                rsp_valid, rsp_ready, rsp_last;
  logic [7:0]          rsp_data;
  logic                irq_n, suspended, addr_clear;

  int checks = 0;
  int errors = 0;
  logic [7:0] ba, bb;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_irq_status #(.NUM_EP(NUM_EP), .MISS_LIMIT(MISS_LIMIT), .EP_IDX_W(EP_IDX_W)) uut (
    .clk(clk), .rst_n(rst_n), .ep_done(ep_done), .sof_pulse(sof_pulse),
    .frame_tick(frame_tick), .bus_reset_det(bus_reset_det), .dma_eot(dma_eot),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_ep(cmd_ep),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_last(rsp_last),
    .rsp_data(rsp_data), .irq_n(irq_n), .suspended(suspended), .addr_clear(addr_clear)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_ep(input logic [NUM_EP-1:0] m);
    @(negedge clk); ep_done = m;
    @(negedge clk); ep_done = '0;
  endtask

  task automatic tick();
    @(negedge clk); frame_tick = 1'b1;
    @(negedge clk); frame_tick = 1'b0;
  endtask

  task automatic sof();
    @(negedge clk); sof_pulse = 1'b1;
    @(negedge clk); sof_pulse = 1'b0;
  endtask

  task automatic ep_ack(input int idx, input logic [NUM_EP-1:0] same_evt);
    @(negedge clk); cmd_valid = 1'b1; cmd_op = 1'b1; cmd_ep = EP_IDX_W'(idx); ep_done = same_evt;
    @(negedge clk); cmd_valid = 1'b0; ep_done = '0;
  endtask

  task automatic read_status(input int stall, input bit sof_a, input bit dma_b,
                             output logic [7:0] a, output logic [7:0] b);
    @(negedge clk); cmd_valid = 1'b1; cmd_op = 1'b0; cmd_ep = '0;
    @(negedge clk); cmd_valid = 1'b0;
    for (int k = 0; k < stall; k++) begin
      chk("R9 stall holds byte A", {29'd0, rsp_valid, rsp_last, cmd_ready}, 32'b100);
      @(negedge clk);
    end
    chk("R9 byte A offered", {30'd0, rsp_valid, rsp_last}, 32'b10);
    a = rsp_data; rsp_ready = 1'b1; sof_pulse = sof_a;
    @(negedge clk); sof_pulse = 1'b0;
    chk("R9 byte B last", {30'd0, rsp_valid, rsp_last}, 32'b11);
    b = rsp_data; dma_eot = dma_b;
    @(negedge clk); dma_eot = 1'b0; rsp_ready = 1'b0;
    chk("R9 back to idle", {30'd0, rsp_valid, cmd_ready}, 32'b01);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ep_done = '0; sof_pulse = 0; frame_tick = 0; bus_reset_det = 0;
    dma_eot = 0; cmd_valid = 0; cmd_op = 0; cmd_ep = '0; rsp_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state: R7, R9
    chk("R7 reset irq_n", {31'd0, irq_n}, 1);
    chk("R9 reset ready/valid", {29'd0, cmd_ready, rsp_valid, suspended}, 32'b100);
    chk("R3 reset addr_clear", {31'd0, addr_clear}, 0);

    // endpoint sweep: R1, R2, R10
    for (int i = 0; i < NUM_EP; i++) begin
      pulse_ep(NUM_EP'(1) << i);
      chk("R7 ep irq low", {31'd0, irq_n}, 0);
      read_status(0, 0, 0, ba, bb);
      chk("R1 byte A ep bit", {24'd0, ba}, 32'(1) << i);
      chk("R6 byte B empty", {24'd0, bb}, 0);
      chk("R2 read keeps ep flag", {31'd0, irq_n}, 0);
      for (int j = 0; j < (1 << EP_IDX_W); j++) begin
        if (j != i) begin
          ep_ack(j, '0);
          chk(j >= NUM_EP ? "R10 out-of-range ack ignored" : "R2 other ack ignored",
              {31'd0, irq_n}, 0);
        end
      end
      ep_ack(i, '0);
      chk("R2 own ack clears", {31'd0, irq_n}, 1);
    end

    // multi-endpoint pattern, R1
    pulse_ep(6'b101101);
    read_status(0, 0, 0, ba, bb);
    chk("R1 multi ep byte A", {24'd0, ba}, 32'h2D);
    for (int j = 0; j < NUM_EP; j++) ep_ack(j, '0);
    chk("R2 all acked", {31'd0, irq_n}, 1);

    // set wins over endpoint ack: R8
    pulse_ep(6'b000100);
    ep_ack(2, 6'b000100);
    read_status(0, 0, 0, ba, bb);
    chk("R8 ep set beats ack", {24'd0, ba}, 32'h04);
    ep_ack(2, '0);

    // DMA with stall: R6, R9, R7
    @(negedge clk); dma_eot = 1'b1;
    @(negedge clk); dma_eot = 1'b0;
    read_status(4, 0, 0, ba, bb);
    chk("R6 dma byte B", {24'd0, bb}, 1);
    chk("R6 dma byte A empty", {24'd0, ba}, 0);
    read_status(0, 0, 0, ba, bb);
    chk("R6 dma cleared by read", {24'd0, bb}, 0);
    chk("R7 irq released", {31'd0, irq_n}, 1);

    // DMA set wins at byte B accept: R8
    @(negedge clk); dma_eot = 1'b1;
    @(negedge clk); dma_eot = 1'b0;
    read_status(0, 0, 1, ba, bb);
    read_status(0, 0, 0, ba, bb);
    chk("R8 dma set beats clear", {24'd0, bb}, 1);
    read_status(0, 0, 0, ba, bb);

    // suspend detection: R4, R5
    tick(); tick();
    chk("R4 two ticks awake", {31'd0, suspended}, 0);
    sof();
    tick(); tick();
    chk("R5 sof restarts count", {31'd0, suspended}, 0);
    tick();
    chk("R4 suspended after limit", {31'd0, suspended}, 1);
    chk("R4 irq on suspend", {31'd0, irq_n}, 0);
    tick(); tick(); tick();
    read_status(0, 0, 0, ba, bb);
    chk("R4 suspend change bit", {24'd0, ba}, 32'h80);
    read_status(0, 0, 0, ba, bb);
    chk("R6 suspend change cleared", {24'd0, ba}, 0);
    chk("R4 no re-set while suspended", {31'd0, irq_n}, 1);
    read_status(0, 1, 0, ba, bb);
    chk("R5 sof wakes", {31'd0, suspended}, 0);
    read_status(0, 0, 0, ba, bb);
    chk("R8 wake change beats clear", {24'd0, ba}, 32'h80);
    chk("R7 idle after wake read", {31'd0, irq_n}, 1);

    // bus reset: R3
    pulse_ep('1);
    @(negedge clk); dma_eot = 1'b1;
    @(negedge clk); dma_eot = 1'b0;
    tick(); tick(); tick();
    chk("R4 suspended before bus reset", {31'd0, suspended}, 1);
    @(negedge clk); bus_reset_det = 1'b1;
    @(negedge clk); bus_reset_det = 1'b0;
    chk("R3 addr_clear pulse", {31'd0, addr_clear}, 1);
    chk("R3 awake after bus reset", {31'd0, suspended}, 0);
    @(negedge clk);
    chk("R3 addr_clear one cycle", {31'd0, addr_clear}, 0);
    read_status(0, 0, 0, ba, bb);
    chk("R3 only bus reset bit", {24'd0, ba}, 32'h40);
    chk("R3 dma cleared", {24'd0, bb}, 0);
    read_status(0, 0, 0, ba, bb);
    chk("R6 bus reset bit cleared", {24'd0, ba}, 0);
    tick(); tick();
    chk("R3 frame count restarted", {31'd0, suspended}, 0);
    chk("R7 final irq high", {31'd0, irq_n}, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule